// File: doc/BRIEF.md
# Alarm Counter Timer with Periodic Restart

This block is a small memory-mapped timekeeping peripheral. A wide up-counter advances once for every slow time-base pulse, which a chip-level synchroniser presents as a single-cycle enable on `tick_en`. In free-running mode the counter keeps climbing. In periodic mode it falls back to zero on the pulse where it equals the programmed 32-bit target. In both modes that equality marks an alarm and latches a pending flag. The flag reaches the interrupt pin only while the mask bit is clear.

Software reaches the block through a single-cycle register port. Word offsets are decoded from `bus_addr`: 0 is the target, 1 is the control word, 2 is the low counter window, 3 is the status word and 4 is the acknowledge word. Read data is combinational and valid in the same cycle as the access. A read of the acknowledge word retires the pending alarm. The counter cannot be written. Only its low 32 bits are visible.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset every readable offset returns zero, `irq` is low, the counter is zero and the control word is zero (stopped, free-running, unmasked).
- R2: The counter advances by exactly one on each clock edge where `tick_en` is high and control bit 0 (run) is set. With run clear, or with `tick_en` low, it holds its value.
- R3: With control bit 1 clear (free-running), a pulse while the count equals the target raises the pending flag, and the count continues upward past the target without restarting.
- R4: With control bit 1 set (periodic), a pulse while the count equals the target sets the count to zero and raises the pending flag on the same edge. A target of N therefore gives a period of N+1 pulses, and a target of 0 alarms on every pulse.
- R5: Writing offset 1 stores bits [2:0] of the write data: bit 0 run, bit 1 periodic, bit 2 mask. The new value acts from the next edge. Reading offset 1 returns those three bits, with every higher bit read as zero.
- R6: The pending flag is raised even while the mask (control bit 2) is set. `irq` is high exactly when the flag is pending and the mask is clear, so clearing the mask while an alarm is pending raises `irq` at once.
- R7: Reading offset 3 returns the pending flag in bit 0, with all other bits zero.
- R8: Reading offset 4 returns zero and clears the pending flag on that edge. It leaves the counter, the target and the control word unchanged.
- R9: If an alarm occurs on the same edge as a read of offset 4, the pending flag remains set.
- R10: The target at offset 0 is a full 32-bit register. It can be rewritten at any time, reads back as written, and governs the very next comparison.
- R11: Reading offset 2 returns the low 32 bits of the counter. Writes to offsets 2, 3 and 4 change nothing, and in particular a write to offset 4 does not clear the pending flag.
- R12: Offsets 5 to 7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base pulse, already synchronised to `clk` |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is in progress |
| irq | output | 1 | Level interrupt: pending and not masked |

## Verification
The assertions assume that `tick_en` is a clean, clock-synchronous level, so they can treat each edge as one pulse or no pulse. They also assume that a bus access lasts exactly one cycle, so that a read of offset 4 retires the alarm only once. The stimulus raises `tick_en` for whole cycles between falling edges and holds each access for one clock period. It drives the simultaneous alarm-and-acknowledge case on purpose, by pulsing the time base in the same cycle as the acknowledge read. Because the bench never needs counts above a few dozen, the high 16 counter bits stay zero and the low window shows the full count.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // Register port address width (word offsets)
  localparam int RTC_ADDR_W = 3;

  // Word offsets decoded by the register bank
  localparam logic [RTC_ADDR_W-1:0] RTC_OFS_TARGET = 3'd0;
  localparam logic [RTC_ADDR_W-1:0] RTC_OFS_CTRL   = 3'd1;
  localparam logic [RTC_ADDR_W-1:0] RTC_OFS_COUNT  = 3'd2;
  localparam logic [RTC_ADDR_W-1:0] RTC_OFS_STATUS = 3'd3;
  localparam logic [RTC_ADDR_W-1:0] RTC_OFS_ACK    = 3'd4;

  // Control word: bit 2 mask, bit 1 periodic, bit 0 run
  localparam int RTC_CTRL_W = 3;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic run;
  } rtc_ctrl_t;

endpackage

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [RTC_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     count_lo,
  input  logic                  pending,
  output logic [DATA_W-1:0]     target_q,
  output rtc_ctrl_t             ctrl_q,
  output logic                  ack_rd,
  output logic [DATA_W-1:0]     bus_rdata
);

  localparam int CTRL_PAD_W = DATA_W - RTC_CTRL_W;
  localparam int STAT_PAD_W = DATA_W - 1;

  logic wr_access;
  logic rd_access;

  assign wr_access = bus_sel & bus_wr;
  assign rd_access = bus_sel & ~bus_wr;

  // Acknowledge is a read side effect only
  assign ack_rd = rd_access && (bus_addr == RTC_OFS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_access) begin
      case (bus_addr)
        RTC_OFS_TARGET: target_q <= bus_wdata;
        RTC_OFS_CTRL:   ctrl_q   <= rtc_ctrl_t'(bus_wdata[RTC_CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_access) begin
      case (bus_addr)
        RTC_OFS_TARGET: bus_rdata = target_q;
        RTC_OFS_CTRL:   bus_rdata = {{CTRL_PAD_W{1'b0}}, ctrl_q};
        RTC_OFS_COUNT:  bus_rdata = count_lo;
        RTC_OFS_STATUS: bus_rdata = {{STAT_PAD_W{1'b0}}, pending};
        default:        bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W  = 48,
  parameter int LOAD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic              periodic,
  input  logic [LOAD_W-1:0] target,
  output logic [CNT_W-1:0]  count_q,
  output logic              adv,
  output logic              hit
);

  // Full-width compare against the zero-extended target
  function automatic logic at_target(logic [CNT_W-1:0] c, logic [LOAD_W-1:0] t);
    return c == CNT_W'(t);
  endfunction

  // Next count after an accepted pulse
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c, logic restart);
    return restart ? '0 : c + CNT_W'(1);
  endfunction

  assign adv = tick_en & run;
  assign hit = adv & at_target(count_q, target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (adv) begin
      count_q <= next_count(count_q, hit & periodic);
    end
  end

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack_rd,
  input  logic mask,
  output logic pending_q,
  output logic irq
);

  // Set wins over clear when both occur on one edge
  function automatic logic next_pending(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= next_pending(pending_q, hit, ack_rd);
    end
  end

  assign irq = pending_q & ~mask;

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [RTC_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);

  logic [DATA_W-1:0] target_q;
  rtc_ctrl_t         ctrl_q;
  logic              ack_rd;
  logic [CNT_W-1:0]  count_q;
  logic              tick_adv;
  logic              alarm_hit;
  logic              pending_q;
  logic              mode_periodic;
  logic              irq_mask;

  assign mode_periodic = ctrl_q.periodic;
  assign irq_mask      = ctrl_q.mask;

  rtc_reg_bank #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_lo  (count_q[DATA_W-1:0]),
    .pending   (pending_q),
    .target_q  (target_q),
    .ctrl_q    (ctrl_q),
    .ack_rd    (ack_rd),
    .bus_rdata (bus_rdata)
  );

  rtc_count_core #(.CNT_W(CNT_W), .LOAD_W(DATA_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run      (ctrl_q.run),
    .periodic (mode_periodic),
    .target   (target_q),
    .count_q  (count_q),
    .adv      (tick_adv),
    .hit      (alarm_hit)
  );

  rtc_irq_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (alarm_hit),
    .ack_rd    (ack_rd),
    .mask      (irq_mask),
    .pending_q (pending_q),
    .irq       (irq)
  );

endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv,
  input logic             hit,
  input logic             periodic,
  input logic             mask,
  input logic             ack_rd,
  input logic             pending,
  input logic             irq,
  input logic [CNT_W-1:0] count
);

  // R2: no accepted pulse, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(count));

  // R2: an accepted pulse without a restart steps by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(hit && periodic)) |=> count == $past(count) + CNT_W'(1));

  // R3: free-running mode runs past the target
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !periodic) |=> count != '0 || $past(count) == {CNT_W{1'b1}});

  // R4: periodic mode restarts at the target
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && periodic) |=> count == '0);

  // R6: an alarm always latches, masked or not
  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending);

  // R6: the mask silences the pin
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  // R6: no interrupt without a pending alarm
  p_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);

  // R8: acknowledge read retires the alarm
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !hit) |=> !pending);

  // R9: a pending alarm survives until acknowledged
  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack_rd) |=> pending);

  // R3/R4: a pending alarm only appears after a match
  p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(hit));

endmodule

bind rtc_alarm_timer rtc_alarm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv      (tick_adv),
  .hit      (alarm_hit),
  .periodic (mode_periodic),
  .mask     (irq_mask),
  .ack_rd   (ack_rd),
  .pending  (pending_q),
  .irq      (irq),
  .count    (count_q)
);

// File: tb/rtc_alarm_timer_tb.sv
module rtc_alarm_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t exp_q[$];

  always #10 clk = ~clk;

  rtc_alarm_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (bus_sel && !bus_wr) begin
      sb_item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: unexpected read, got %h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // Driver: read with expected value, optionally with a time-base pulse
  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag, input bit tk = 1'b0);
    sb_item_t it;
    @(negedge clk);
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    bus_sel  = 1'b1;
    bus_wr   = 1'b0;
    bus_addr = a;
    tick_en  = tk;
    @(negedge clk);
    bus_sel = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel   = 1'b1;
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_wr  = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #2;
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset read");
    chk_irq(1'b0, "R1 irq after reset");

    // R10 / R5: target and control readback
    wr(3'd0, 32'd5);
    wr(3'd1, 32'd1);
    rd(3'd0, 32'd5, "R10 target readback");
    rd(3'd1, 32'd1, "R5 control readback");

    // R2: advance and hold
    ticks(3);
    rd(3'd2, 32'd3, "R2 three pulses");
    wr(3'd1, 32'd0);
    ticks(4);
    rd(3'd2, 32'd3, "R2 hold while stopped");
    wr(3'd1, 32'd1);
    repeat (5) @(negedge clk);
    rd(3'd2, 32'd3, "R2 hold without pulse");

    // R3: free-running passes the target
    ticks(2);
    rd(3'd2, 32'd5, "R3 count at target");
    rd(3'd3, 32'd0, "R3 no alarm before match pulse");
    ticks(1);
    rd(3'd3, 32'd1, "R7 status after alarm");
    rd(3'd2, 32'd6, "R3 count continues past target");
    chk_irq(1'b1, "R6 irq unmasked");

    // R8: acknowledge read
    rd(3'd4, 32'd0, "R8 ack read data");
    rd(3'd3, 32'd0, "R8 status cleared");
    chk_irq(1'b0, "R8 irq dropped");
    rd(3'd2, 32'd6, "R8 count untouched");
    rd(3'd1, 32'd1, "R8 control untouched");
    rd(3'd0, 32'd5, "R8 target untouched");

    // R4 / R6: periodic, masked
    wr(3'd0, 32'd8);
    wr(3'd1, 32'd7);
    ticks(2);
    rd(3'd2, 32'd8, "R4 count reaches target");
    ticks(1);
    rd(3'd2, 32'd0, "R4 wrap to zero");
    rd(3'd3, 32'd1, "R6 flag set while masked");
    chk_irq(1'b0, "R6 masked irq low");
    rd(3'd1, 32'd7, "R5 control all bits");
    wr(3'd1, 32'd3);
    chk_irq(1'b1, "R6 unmask raises irq");
    rd(3'd4, 32'd0, "R8 ack");
    rd(3'd3, 32'd0, "R8 status cleared periodic");

    // R9: alarm together with acknowledge
    ticks(8);
    rd(3'd2, 32'd8, "R4 period count");
    rd(3'd4, 32'd0, "R9 ack with alarm", 1'b1);
    rd(3'd3, 32'd1, "R9 flag kept");
    rd(3'd2, 32'd0, "R4 wrap after nine pulses");
    rd(3'd4, 32'd0, "R8 ack");

    // R10: rewrite target while running
    wr(3'd0, 32'd3);
    rd(3'd0, 32'd3, "R10 new target");
    ticks(3);
    rd(3'd3, 32'd0, "R10 no alarm before new target");
    ticks(1);
    rd(3'd3, 32'd1, "R10 alarm at new target");
    rd(3'd2, 32'd0, "R10 wrap at new target");

    // R11: writes to read-only offsets
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd3, 32'd1, "R11 ack write ignored");
    wr(3'd2, 32'h0000_1234);
    rd(3'd2, 32'd0, "R11 count write ignored");
    wr(3'd3, 32'd0);
    rd(3'd3, 32'd1, "R11 status write ignored");
    rd(3'd4, 32'd0, "R8 ack");

    // R12: unmapped offsets
    wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd6, 32'd0, "R12 unmapped read");
    rd(3'd0, 32'd3, "R12 target unchanged");
    rd(3'd1, 32'd3, "R12 control unchanged");

    // R4: target of zero alarms every pulse
    wr(3'd0, 32'd0);
    ticks(1);
    rd(3'd2, 32'd0, "R4 zero target stays at zero");
    rd(3'd3, 32'd1, "R4 zero target alarms");

    // R5: upper control bits ignored, run cleared
    wr(3'd1, 32'hFFFF_FFF8);
    rd(3'd1, 32'd0, "R5 upper bits ignored");
    wr(3'd0, 32'd9);
    ticks(2);
    rd(3'd2, 32'd0, "R5 run cleared stops count");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule